// File: doc/BRIEF.md
# Per-Bit Line Interrupt Detector Bank

This block watches a vector of already-sampled input lines and turns a configured condition on each line into a sticky per-line status flag. Every line has its own enable bit and a three-bit trigger selection spread over three parallel configuration words. The selection chooses falling edge, rising edge, both edges, low level or high level. Software clears a flag by writing a one to its status position. The block drives one combined interrupt output whenever any enabled line has its flag set.

Edges are found by comparing each line against its value in the previous clock cycle. That previous-value register simply follows the input every cycle, including during reset, so the first cycle after reset never sees a spurious change. Configuration and status are reached through a simple word-addressed write port and a combinational read port. The word order is the one a software driver expects for a bank of this kind.

Top module: `irqdet_bank`

## Requirements
- R1: After a synchronous reset, word 0 (enable) reads all zeros, word 1 (type0) all ones, word 2 (type1) all ones, word 3 (type2) all zeros, word 4 (status) all zeros, and `irq` is 0.
- R2: Word addresses 0 to 4 select enable, type0, type1, type2 and status. A write to words 0 to 3 is read back unchanged from the next cycle on. Words 5 to 7 read as zero, and writes to them change no register.
- R3: With type1=0, a line triggers on edges. With type2=0 and type0=0 it triggers on a falling edge (1 then 0 on consecutive cycles). With type2=0 and type0=1 it triggers on a rising edge. With type2=1 it triggers on either edge, whatever the value of type0. An unchanged line never triggers in these modes.
- R4: With type1=1, a line triggers on level, ignoring type2. With type0=0 it triggers while the line is 0, and with type0=1 it triggers while the line is 1.
- R5: A status bit is set at the clock edge that sees its trigger condition, and only if its enable bit is 1 at that edge. A line whose enable bit is 0 never sets its status bit.
- R6: A write to word 4 clears exactly the status bits written as one and leaves the others untouched. A clear takes precedence over a trigger at the same edge. A level that is still present sets the bit again at the following edge.
- R7: `irq` is the OR over all lines of (status AND enable), taken from the registered values. A set status bit whose enable bit has been cleared keeps its value but does not drive `irq`.
- R8: Lines are independent: several lines can trigger at the same edge, and each one sets only its own status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | LINES | Write data; for status, a mask of bits to clear |
| rd_addr | input | 3 | Word address of the read |
| rd_data | output | LINES | Combinational read data |
| line_in | input | LINES | Sampled input lines |
| irq | output | 1 | Combined interrupt request |

## Verification
The trigger selection is exercised with a table of one-line transitions: 0 to 1, 1 to 0, and steady 0 or 1, under every type combination, with the line enabled and disabled. This separates edge decoding from level decoding and shows that type2 is ignored in level mode while type0 is ignored in both-edge mode. A wide rising pattern across many lines at once shows the lines are independent. Further cases cover the clear-to-status path: zero and partial clear masks, a clear that coincides with a rising edge, and a level that re-sets its flag one cycle after it is cleared. A status bit that stays set after its enable bit is removed shows that `irq` is gated by enable.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;

    typedef enum logic [2:0] {
        WORD_EN   = 3'd0,
        WORD_T0   = 3'd1,
        WORD_T1   = 3'd2,
        WORD_T2   = 3'd3,
        WORD_STAT = 3'd4
    } word_e;

    typedef enum logic [2:0] {
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH,
        TRIG_LOW,
        TRIG_HIGH
    } trig_e;

    typedef struct packed {
        logic t2;
        logic t1;
        logic t0;
    } trig_cfg_t;

    // Level selection (t1) dominates; t2 picks both edges in edge mode.
    function automatic trig_e decode_trig(trig_cfg_t c);
        if (c.t1)
            return c.t0 ? TRIG_HIGH : TRIG_LOW;
        else if (c.t2)
            return TRIG_BOTH;
        else
            return c.t0 ? TRIG_RISE : TRIG_FALL;
    endfunction

    function automatic logic trig_hit(trig_e m, logic cur, logic prv);
        case (m)
            TRIG_FALL: return prv & ~cur;
            TRIG_RISE: return ~prv & cur;
            TRIG_BOTH: return prv ^ cur;
            TRIG_LOW:  return ~cur;
            TRIG_HIGH: return cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irqdet_detect.sv
module irqdet_detect
    import irqdet_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] t0,
    input  logic [LINES-1:0] t1,
    input  logic [LINES-1:0] t2,
    output logic [LINES-1:0] hit
);

    logic [LINES-1:0] prev_q;

    // Follows the line in every cycle, reset included, so no false edge appears.
    always_ff @(posedge clk) begin
        prev_q <= line_in;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        trig_cfg_t cfg;
        always_comb begin
            cfg = '{t2: t2[i], t1: t1[i], t0: t0[i]};
            hit[i] = trig_hit(decode_trig(cfg), line_in[i], prev_q[i]);
        end
    end

    // R3: an edge-mode hit needs a change of the line
    p_edge_change_r3: assert property (@(posedge clk) disable iff (rst)
        (hit & ~t1 & ~(line_in ^ prev_q)) == '0);

endmodule

// File: rtl/irqdet_regs.sv
module irqdet_regs
    import irqdet_pkg::*;
#(
    parameter int LINES = 32,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LINES-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [LINES-1:0] rd_data,
    input  logic [LINES-1:0] hit,
    output logic [LINES-1:0] en_q,
    output logic [LINES-1:0] t0_q,
    output logic [LINES-1:0] t1_q,
    output logic [LINES-1:0] t2_q,
    output logic [LINES-1:0] stat_q
);

    localparam logic [LINES-1:0] ALL_ONES = '1;

    logic             stat_wr;
    logic [LINES-1:0] clr_mask;
    logic [LINES-1:0] stat_d;
    logic             seen_q;

    assign stat_wr  = wr_en && (wr_addr == AW'(WORD_STAT));
    assign clr_mask = stat_wr ? wr_data : '0;
    // Clear wins over a same-edge trigger.
    assign stat_d   = (stat_q | (hit & en_q)) & ~clr_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            t0_q   <= ALL_ONES;
            t1_q   <= ALL_ONES;
            t2_q   <= '0;
            stat_q <= '0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            stat_q <= stat_d;
            if (wr_en) begin
                case (wr_addr)
                    AW'(WORD_EN): en_q <= wr_data;
                    AW'(WORD_T0): t0_q <= wr_data;
                    AW'(WORD_T1): t1_q <= wr_data;
                    AW'(WORD_T2): t2_q <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            AW'(WORD_EN):   rd_data = en_q;
            AW'(WORD_T0):   rd_data = t0_q;
            AW'(WORD_T1):   rd_data = t1_q;
            AW'(WORD_T2):   rd_data = t2_q;
            AW'(WORD_STAT): rd_data = stat_q;
            default:        rd_data = '0;
        endcase
    end

    // R5: a newly set status bit had its enable set
    p_set_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        seen_q |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

    // R6: written ones are cleared at the next edge
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((stat_q & $past(wr_data)) == '0));

    // R6: without a clear write, no status bit falls
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> (($past(stat_q) & ~stat_q) == '0));

endmodule

// File: rtl/irqdet_bank.sv
module irqdet_bank
    import irqdet_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [LINES-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [LINES-1:0] rd_data,
    input  logic [LINES-1:0] line_in,
    output logic             irq
);

    logic [LINES-1:0] hit;
    logic [LINES-1:0] en_q;
    logic [LINES-1:0] t0_q;
    logic [LINES-1:0] t1_q;
    logic [LINES-1:0] t2_q;
    logic [LINES-1:0] stat_q;

    irqdet_detect #(.LINES(LINES)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .t0      (t0_q),
        .t1      (t1_q),
        .t2      (t2_q),
        .hit     (hit)
    );

    irqdet_regs #(.LINES(LINES), .AW(3)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .hit     (hit),
        .en_q    (en_q),
        .t0_q    (t0_q),
        .t1_q    (t1_q),
        .t2_q    (t2_q),
        .stat_q  (stat_q)
    );

    assign irq = |(stat_q & en_q);

    // R7: the request needs at least one enabled line
    p_irq_en_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_q != '0));

    // R7: the request needs at least one set flag
    p_irq_stat_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q != '0));

endmodule

// File: tb/irqdet_bank_bench.sv
module irqdet_bank_bench;

    localparam int LINES = 32;
    localparam int BIT   = 5;
    localparam int NROWS = 16;

    // Row: [6:4] {t2,t1,t0}, [3] enable, [2] line before, [1] line after, [0] expected flag
    localparam logic [6:0] VEC [NROWS] = '{
        7'b000_1_10_1, 7'b000_1_01_0, 7'b000_1_00_0,
        7'b001_1_01_1, 7'b001_1_10_0,
        7'b101_1_01_1, 7'b101_1_10_1, 7'b101_1_11_0,
        7'b100_1_10_1,
        7'b011_1_11_1, 7'b011_1_00_0,
        7'b010_1_00_1, 7'b010_1_11_0,
        7'b111_1_11_1, 7'b110_1_00_1,
        7'b001_0_01_0
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [LINES-1:0] wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [LINES-1:0] rd_data;
    logic [LINES-1:0] line_in = '0;
    logic             irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irqdet_bank #(.LINES(LINES)) u_irqdet_bank (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .line_in, .irq
    );

    task automatic check(string req, logic [LINES-1:0] got, logic [LINES-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [LINES-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [LINES-1:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [LINES-1:0] v;
        line_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(3'd0, v); check("R1 enable", v, '0);
        rd(3'd1, v); check("R1 type0", v, '1);
        rd(3'd2, v); check("R1 type1", v, '1);
        rd(3'd3, v); check("R1 type2", v, '0);
        rd(3'd4, v); check("R1 status", v, '0);
        check("R1 irq", {31'd0, irq}, '0);

        // R2: read-back and unused words
        wr(3'd1, 32'h1234_5678); rd(3'd1, v); check("R2 type0 readback", v, 32'h1234_5678);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); check("R2 word5 reads zero", v, '0);
        rd(3'd0, v); check("R2 word5 write ignored (enable)", v, '0);
        rd(3'd1, v); check("R2 word5 write ignored (type0)", v, 32'h1234_5678);

        // R3 R4 R5: table walk on one line
        for (int r = 0; r < NROWS; r++) begin
            logic [6:0] row;
            row = VEC[r];
            wr(3'd0, '0);
            line_in = {LINES{row[2]}};
            wr(3'd1, {LINES{row[4]}});
            wr(3'd2, {LINES{row[5]}});
            wr(3'd3, {LINES{row[6]}});
            wr(3'd4, '1);
            wr(3'd0, row[3] ? (32'd1 << BIT) : '0);
            line_in = {LINES{row[1]}};
            step();
            rd(3'd4, v);
            check($sformatf("R3/R4/R5 row %0d flag", r), {31'd0, v[BIT]}, {31'd0, row[0]});
            check($sformatf("R7 row %0d irq", r), {31'd0, irq}, {31'd0, row[0]});
        end

        // R8: many lines rising at once
        wr(3'd0, '0);
        line_in = '0;
        wr(3'd1, '1); wr(3'd2, '0); wr(3'd3, '0);
        wr(3'd4, '1);
        wr(3'd0, '1);
        line_in = 32'hA5A5_F00F;
        step();
        rd(3'd4, v); check("R8 independent lines", v, 32'hA5A5_F00F);

        // R6: zero mask keeps, partial mask clears only its bits
        wr(3'd4, '0);
        rd(3'd4, v); check("R6 zero write keeps", v, 32'hA5A5_F00F);
        wr(3'd4, 32'h0000_F00F);
        rd(3'd4, v); check("R6 partial clear", v, 32'hA5A5_0000);

        // R7: disabled line keeps status but no irq
        wr(3'd0, 32'h0000_FFFF);
        rd(3'd4, v); check("R7 status kept", v, 32'hA5A5_0000);
        check("R7 irq gated by enable", {31'd0, irq}, '0);

        // R6: clear beats a same-edge rising trigger
        wr(3'd4, '1);
        line_in = '0; step();
        wr(3'd0, 32'h1);
        line_in = 32'h1;
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R6 clear wins same edge", v, '0);

        // R6: level re-asserts one cycle after clear
        wr(3'd2, '1);
        step();
        rd(3'd4, v); check("R6 level sets", v, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R6 cleared cycle", v, '0);
        step();
        rd(3'd4, v); check("R6 level re-asserts", v, 32'h1);

        // R5: level present but enable off never sets
        wr(3'd0, '0);
        wr(3'd4, '1);
        step();
        rd(3'd4, v); check("R5 disabled level", v, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule